// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 32-bit integers one multiplier bit at a time. A one-cycle `start` pulse loads the operands and a 2-bit operation code. The operation code selects one of four results: the low word of the product, or the high word with the operands treated as signed×signed, unsigned×unsigned or signed×unsigned. The block raises `busy` while it works. When the result is ready it pulses `done` for one cycle and presents the 32-bit `result`.

Signs are handled around an unsigned core. Each operand that is read as signed is first turned into its magnitude, and the two signs are recorded. The core then runs 32 shift-and-add iterations, which build a 64-bit unsigned product. If exactly one operand was negative, the whole 64-bit product is negated in two's complement. Only after that step is the requested half taken. This order is what makes the high words correct for mixed signs.

A host waits until `busy` is low, pulses `start`, and then either waits for `done` or counts the fixed latency.

Top module: `seq_mul_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `busy`, `done` and `result` are all zero.
- R2: A `start` seen at a clock edge while `busy` is low loads `op`, `opa` and `opb`, and `busy` is high from the next cycle on.
- R3: A `start` seen while `busy` is high has no effect: the running operation keeps its operands, its op code and its completion cycle.
- R4: `done` is high for exactly one cycle, 33 clock edges after the edge that accepted `start`. `busy` falls at that same edge, and `busy` stays high for every cycle in between.
- R5: Op code 2'b00 returns bits [31:0] of the product.
- R6: Op code 2'b01 returns bits [63:32] of the product of both operands read as two's-complement signed.
- R7: Op code 2'b10 returns bits [63:32] of the product of both operands read as unsigned.
- R8: Op code 2'b11 returns bits [63:32] of the product of `opa` read as signed and `opb` read as unsigned.
- R9: An operand of 32'h8000_0000 that is read as signed is treated as magnitude 2^31 and gives the exact product.
- R10: `result` keeps its value from one `done` until the next `done`.
- R11: Each iteration adds the shifted multiplicand into the partial product only when the current low multiplier bit is 1. The multiplicand then shifts left by one and the multiplier shifts right by one. For example, 2 × 3 yields 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op | input | 2 | Product variant: 00 low, 01 high s×s, 10 high u×u, 11 high s×u |
| opa | input | 32 | First operand (multiplicand) |
| opb | input | 32 | Second operand (multiplier) |
| result | output | 32 | Selected product word |
| done | output | 1 | One-cycle pulse when `result` is updated |
| busy | output | 1 | High from acceptance until completion |

## Verification
The assertions check the following on every cycle:
- `done` is a one-cycle pulse that ends `busy`.
- An accepted start raises `busy`.
- An operation cannot end before its finish phase.
- `result` does not move between completions.
- Each datapath step obeys the shift-add rule.

Only the bench's scenarios can show the rest:
- that the returned words are the correct products for all four op codes, including the most negative operand;
- that completion lands exactly 33 edges after acceptance;
- that a start pulse during a run leaves that run's result unchanged.

// File: rtl/mulu_pkg.sv
`timescale 1ns/1ps
package mulu_pkg;

  typedef enum logic [1:0] {
    MOP_LO    = 2'b00,
    MOP_HI_SS = 2'b01,
    MOP_HI_UU = 2'b10,
    MOP_HI_SU = 2'b11
  } mop_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIN  = 2'b10
  } mstate_e;

  // first operand is read as signed for s*s and s*u high words
  function automatic logic a_signed(input logic [1:0] op);
    return (op == MOP_HI_SS) || (op == MOP_HI_SU);
  endfunction

  // second operand is read as signed only for the s*s high word
  function automatic logic b_signed(input logic [1:0] op);
    return (op == MOP_HI_SS);
  endfunction

  function automatic logic take_high(input logic [1:0] op);
    return (op != MOP_LO);
  endfunction

endpackage

// File: rtl/mulu_prep.sv
`timescale 1ns/1ps
// Operand conditioning: magnitudes and the sign of the final product.
module mulu_prep #(
  parameter int W = 32
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] mag_a,
  output logic [W-1:0] mag_b,
  output logic         neg_prod
);
  import mulu_pkg::*;

  // Magnitude of a W-bit value; the most negative value maps to 2^(W-1),
  // which still fits in W unsigned bits (R9).
  function automatic logic [W-1:0] magnitude(input logic [W-1:0] x,
                                             input logic         is_signed);
    if (is_signed && x[W-1]) return (~x) + {{(W-1){1'b0}}, 1'b1};
    return x;
  endfunction

  logic a_neg, b_neg;

  always_comb begin
    a_neg    = a_signed(op) && opa[W-1];
    b_neg    = b_signed(op) && opb[W-1];
    mag_a    = magnitude(opa, a_signed(op));
    mag_b    = magnitude(opb, b_signed(op));
    neg_prod = a_neg ^ b_neg;
  end

endmodule

// File: rtl/mulu_ctrl.sv
`timescale 1ns/1ps
// Sequencer: idle, W shift-add steps, one finish cycle.
module mulu_ctrl #(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step,
  output logic finish
);
  import mulu_pkg::*;

  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  mstate_e       state_q;
  logic [CW-1:0] iter_q;

  assign busy   = (state_q != ST_IDLE);
  assign load   = (state_q == ST_IDLE) && start;
  assign step   = (state_q == ST_RUN);
  assign finish = (state_q == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_RUN;
          iter_q  <= '0;
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST) state_q <= ST_FIN;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: an accepted start makes the unit busy in the next cycle
  assert_busy_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R3: a running operation is never cut short by a further start
  assert_start_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !finish) |=> busy);

  // R4: the finish phase is always reached from the iteration phase
  assert_fin_after_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> $past(step));

endmodule

// File: rtl/mulu_datapath.sv
`timescale 1ns/1ps
// Shift-add registers: 2W multiplicand, W multiplier, 2W product.
module mulu_datapath #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   mag_a,
  input  logic [W-1:0]   mag_b,
  input  logic           neg_in,
  output logic [2*W-1:0] full_prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] mcand_q;
  logic [W-1:0]  mplier_q;
  logic [PW-1:0] prod_q;
  logic          neg_q;

  // event wires for the assertions
  logic          add_now;
  logic [PW-1:0] prod_next;

  // one iteration of the shift-add rule (R11)
  function automatic logic [PW-1:0] accumulate(input logic [PW-1:0] acc,
                                               input logic [PW-1:0] addend,
                                               input logic          bit_set);
    return bit_set ? (acc + addend) : acc;
  endfunction

  // two's complement of the full double-width value
  function automatic logic [PW-1:0] apply_sign(input logic [PW-1:0] v,
                                               input logic          neg);
    return neg ? ((~v) + {{(PW-1){1'b0}}, 1'b1}) : v;
  endfunction

  assign add_now   = mplier_q[0];
  assign prod_next = accumulate(prod_q, mcand_q, add_now);
  assign full_prod = apply_sign(prod_q, neg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      prod_q   <= '0;
      neg_q    <= 1'b0;
    end else if (load) begin
      mcand_q  <= {{W{1'b0}}, mag_a};
      mplier_q <= mag_b;
      prod_q   <= '0;
      neg_q    <= neg_in;
    end else if (step) begin
      prod_q   <= prod_next;
      mcand_q  <= mcand_q << 1;
      mplier_q <= mplier_q >> 1;
    end
  end

  // R11: the multiplier shifts right by one on every step
  assert_mplier_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (mplier_q == ($past(mplier_q) >> 1)));

  // R11: a zero multiplier bit leaves the partial product unchanged
  assert_skip_add_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !add_now) |=> (prod_q == $past(prod_q)));

  // R11: the multiplicand doubles on every step
  assert_mcand_shift_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (mcand_q == ($past(mcand_q) << 1)));

endmodule

// File: rtl/seq_mul_unit.sv
`timescale 1ns/1ps
module seq_mul_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] result,
  output logic         done,
  output logic         busy
);
  import mulu_pkg::*;

  localparam int PW = 2 * W;

  logic [W-1:0]  mag_a, mag_b;
  logic          neg_prod;
  logic          load, step, finish;
  logic [PW-1:0] full_prod;
  logic [1:0]    op_q;
  logic [W-1:0]  sel_word;

  mulu_prep #(.W(W)) u_prep (
    .op       (op),
    .opa      (opa),
    .opb      (opb),
    .mag_a    (mag_a),
    .mag_b    (mag_b),
    .neg_prod (neg_prod)
  );

  mulu_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .load   (load),
    .step   (step),
    .finish (finish)
  );

  mulu_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg_in    (neg_prod),
    .full_prod (full_prod)
  );

  // half selection happens after the sign has been applied
  assign sel_word = take_high(op_q) ? full_prod[PW-1:W] : full_prod[W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q   <= MOP_LO;
      result <= '0;
      done   <= 1'b0;
    end else begin
      if (load) op_q <= op;
      done <= finish;
      if (finish) result <= sel_word;
    end
  end

  // R4: done never lasts more than one cycle
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: done coincides with the unit leaving the busy state
  assert_done_ends_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R10: result only changes together with done
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

// File: tb/sim_seq_mul_unit.sv
`timescale 1ns/1ps
module sim_seq_mul_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] result;
  logic        done;
  logic        busy;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  seq_mul_unit u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op),
    .opa(opa), .opb(opb), .result(result), .done(done), .busy(busy)
  );

  // behavioural reference: 64-bit multiply in plain integer arithmetic
  function automatic logic [31:0] expect_word(input logic [1:0] o,
                                              input logic [31:0] a,
                                              input logic [31:0] b);
    longint sa, sb, p;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (o)
      2'b00: begin p = longint'({32'h0, a}) * longint'({32'h0, b}); return p[31:0];  end // R5
      2'b01: begin p = sa * sb;                                   return p[63:32]; end // R6
      2'b10: begin p = longint'({32'h0, a}) * longint'({32'h0, b}); return p[63:32]; end // R7
      default: begin p = sa * longint'({32'h0, b});               return p[63:32]; end // R8
    endcase
  endfunction

  // cycle-level model state
  bit          m_busy = 0;
  bit          m_done = 0;
  int          m_left = 0;
  logic [31:0] m_pend = '0;
  logic [31:0] m_res  = '0;
  logic [1:0]  m_op   = 2'b00;
  string       m_tag  = "R1";
  string       cur_tag = "R5";

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_left = 0; m_res = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_res = m_pend;
        end
      end else if (start) begin
        m_busy = 1; m_left = 33;                   // R2, R4
        m_pend = expect_word(op, opa, opb);
        m_op   = op;
        m_tag  = cur_tag;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      check(busy == m_busy, "R4", "busy", {31'h0, busy}, {31'h0, m_busy});
      check(done == m_done, "R4", "done", {31'h0, done}, {31'h0, m_done});
      if (m_done)
        check(result === m_res, m_tag, "result at done", result, m_res);
      else
        check(result === m_res, "R10", "result held", result, m_res);
    end
  end

  task automatic do_op(input logic [1:0] o, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    @(negedge clk);
    while (busy) @(negedge clk);
    cur_tag = tag;
    op = o; opa = a; opb = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op = ~o; opa = ~a; opb = b ^ 32'h5a5a_a5a5;   // inputs must not matter now
    repeat (34) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", {31'h0, busy}, 32'h0);
    check(done == 1'b0, "R1", "done in reset", {31'h0, done}, 32'h0);
    check(result == 32'h0, "R1", "result in reset", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(result == 32'h0 && !busy && !done, "R1", "after reset", result, 32'h0);
    cmp_on = 1;

    do_op(2'b00, 32'd2, 32'd3, "R11");                // 2 x 3 = 6
    check(result == 32'd6, "R11", "2x3", result, 32'd6);
    do_op(2'b00, 32'd0, 32'hffff_ffff, "R5");
    do_op(2'b00, 32'hffff_ffff, 32'hffff_ffff, "R5");
    do_op(2'b01, 32'hffff_ffff, 32'hffff_ffff, "R6");
    do_op(2'b01, 32'hffff_fff9, 32'd1000, "R6");
    do_op(2'b10, 32'hffff_ffff, 32'hffff_ffff, "R7");
    do_op(2'b10, 32'h8000_0000, 32'h0000_0002, "R7");
    do_op(2'b11, 32'hffff_ffff, 32'hffff_ffff, "R8");
    do_op(2'b11, 32'h7fff_ffff, 32'hffff_ffff, "R8");
    do_op(2'b01, 32'h8000_0000, 32'h8000_0000, "R9");
    check(result == 32'h4000_0000, "R9", "min x min high", result, 32'h4000_0000);
    do_op(2'b01, 32'h8000_0000, 32'h0000_0001, "R9");
    do_op(2'b11, 32'h8000_0000, 32'hffff_ffff, "R9");
    do_op(2'b00, 32'h8000_0000, 32'h8000_0000, "R9");

    // R3: a second start during a run is ignored
    @(negedge clk);
    while (busy) @(negedge clk);
    cur_tag = "R3";
    op = 2'b01; opa = 32'hffff_fffd; opb = 32'd7; start = 1'b1;
    @(negedge clk);
    repeat (10) @(negedge clk);
    op = 2'b10; opa = 32'h1234_5678; opb = 32'h9abc_def0;   // start still high
    repeat (5) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    check(result == 32'hffff_ffff, "R3", "result of first op", result, 32'hffff_ffff);

    // mixed patterns across all op codes
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      a = 32'h9e37_79b9 * (i + 1) ^ (32'h1 << i);
      b = 32'h7f4a_7c15 * (i + 3) + i;
      do_op(2'(i), a, b, (i % 4 == 0) ? "R5" : (i % 4 == 1) ? "R6" :
                         (i % 4 == 2) ? "R7" : "R8");
    end

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL R4 watchdog: actual %h expected %h", 32'h1, 32'h0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule